// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets an external serial master read and write a 32-entry register file through a four-wire mode-0 serial link. Each chip-select frame carries one or more bytes. The first byte of an access is a command: its top bit picks write or read, and its low five bits pick the register. A write command is followed by one data byte. A read command makes the block load the addressed register into its output shifter at the falling clock edge that ends the command byte. The register then goes out during the next byte. The master's bytes in that slot are decoded as the next command, so accesses can be chained back to back within one frame.

The register file itself lies outside the block and is reached over a plain parallel port: address out, write data out, a one-cycle write strobe and read data in. Addresses 0, 1 and 2 hold status words. They cannot be written, and when read their top bit is replaced by a computed parity bit. The serial pins are sampled on the system clock and are assumed to be already synchronised to it. The data output has an enable for tri-state, and an input selects push-pull or open-drain drive.

Top module: `spi_rw_slave`

## Requirements
- R1: Mode 0 timing. Input bits are taken on rising serial-clock edges, and the output bit changes only after falling serial-clock edges, so it stays stable while the serial clock is high.
- R2: Bits travel MSB first. In a command byte, bit 7 set means write and bit 7 clear means read, bits 4..0 are the register address, and bits 6..5 have no effect.
- R3: While chip select (active low) is high, and out of reset, the output enable is low and the write strobe is low.
- R4: With the open-drain input high, the output is enabled only while it drives a 0. With it low, the output is enabled for the whole frame.
- R5: After all 8 bits of a write's data byte are taken, the write strobe pulses for exactly one system cycle, carrying the command's address and that data byte.
- R6: A read loads the addressed register at the falling edge of the command byte's 8th clock. The register goes out MSB first during the following byte.
- R7: The byte received while read data goes out is decoded as the next command, so reads and writes chain within one frame.
- R8: For addresses 0..2, bit 7 of the returned byte is 1 when bits 6..0 hold an odd number of ones and 0 otherwise. Other addresses return the register unchanged.
- R9: A write addressed to 0..2 produces no write strobe.
- R10: Raising chip select mid-byte discards the partial byte and aborts any pending write. The next frame starts with a fresh command byte.
- R11: During the first byte of a frame the output shifts out zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from master |
| odMode | input | 1 | 1 selects open-drain output drive, 0 push-pull |
| misoOut | output | 1 | Serial data to master |
| misoOe | output | 1 | Output enable for the serial data pin |
| regAddr | output | 5 | Register file address |
| regWrData | output | 8 | Register file write data |
| regWrEn | output | 1 | One-cycle register write strobe |
| regRdData | input | 8 | Register file read data at regAddr |

## Verification
If the bit counter drifts, the byte boundaries in the decode slip. A wrong address or data then shows up on the write strobe one or two system cycles after the byte ends, and a shifted read byte shows on the output in the very next byte. The bench keeps its own model of the register file and of each frame's expected output. It compares every serial bit and every write strobe as they happen, including frames cut short mid-byte, which a stale counter would misalign in the next frame. A wrong state in the load or parity path shows up in the first returned byte after the read command.

// File: rtl/spi_rw_pkg.sv
package spi_rw_pkg;

  typedef enum logic {
    PH_CMD   = 1'b0,
    PH_WDATA = 1'b1
  } phase_e;

  // Strobes from sequencer to datapath, valid for one system cycle
  typedef struct packed {
    logic clear;        // frame inactive
    logic sampleBit;    // rising serial edge
    logic captureCmd;   // last bit of a command byte
    logic commitWrite;  // last bit of a write data byte
    logic loadRead;     // falling edge ending a read command
    logic shiftOut;     // any other falling edge
  } ctrl_strobe_t;

endpackage

// File: rtl/spi_rw_ctrl.sv
module spi_rw_ctrl
  import spi_rw_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sclk,
  input  logic         rxMsb,
  output ctrl_strobe_t strb
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic             sclkQ;
  logic [CNT_W-1:0] bitCnt;
  phase_e           phase;
  logic             rdPending;
  logic             rise;
  logic             fall;
  logic             byteDone;

  assign rise     = !csN && sclk && !sclkQ;
  assign fall     = !csN && !sclk && sclkQ;
  assign byteDone = rise && (bitCnt == LAST_BIT);

  always_comb begin
    strb             = '0;
    strb.clear       = csN;
    strb.sampleBit   = rise;
    strb.captureCmd  = byteDone && (phase == PH_CMD);
    strb.commitWrite = byteDone && (phase == PH_WDATA);
    strb.loadRead    = fall && rdPending;
    strb.shiftOut    = fall && !rdPending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ     <= 1'b0;
      bitCnt    <= '0;
      phase     <= PH_CMD;
      rdPending <= 1'b0;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        bitCnt    <= '0;
        phase     <= PH_CMD;
        rdPending <= 1'b0;
      end else begin
        if (rise) bitCnt <= bitCnt + 1'b1;
        if (strb.captureCmd) begin
          phase     <= rxMsb ? PH_WDATA : PH_CMD;
          rdPending <= !rxMsb;
        end
        if (strb.commitWrite) phase <= PH_CMD;
        if (fall) rdPending <= 1'b0;
      end
    end
  end

  // R10: a deselected frame leaves the sequencer at a byte start
  p_frame_reset_r10: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (bitCnt == '0 && phase == PH_CMD && !rdPending));

  // R6: a pending read is consumed by the very next falling edge
  p_read_single_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRead |=> !rdPending);

endmodule

// File: rtl/spi_rw_datapath.sv
module spi_rw_datapath
  import spi_rw_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int ADDR_W     = 5,
  parameter int NUM_STATUS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  logic              csN,
  input  logic              mosi,
  input  logic              odMode,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              rxMsb,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              misoOut,
  output logic              misoOe
);

  localparam logic [ADDR_W-1:0] STATUS_LIMIT = ADDR_W'(NUM_STATUS);

  logic [BYTE_W-2:0] shiftIn;
  logic [BYTE_W-1:0] shiftOutQ;
  logic [ADDR_W-1:0] addrQ;
  logic [BYTE_W-1:0] wrDataQ;
  logic              wrEnQ;
  logic [BYTE_W-1:0] rdWord;
  logic              isStatus;

  assign rxMsb    = shiftIn[BYTE_W-2];
  assign isStatus = addrQ < STATUS_LIMIT;

  always_comb begin
    rdWord = regRdData;
    if (isStatus) rdWord[BYTE_W-1] = ^regRdData[BYTE_W-2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn   <= '0;
      shiftOutQ <= '0;
      addrQ     <= '0;
      wrDataQ   <= '0;
      wrEnQ     <= 1'b0;
    end else begin
      wrEnQ <= 1'b0;
      if (strb.clear) begin
        shiftIn   <= '0;
        shiftOutQ <= '0;
      end else begin
        if (strb.sampleBit) shiftIn <= {shiftIn[BYTE_W-3:0], mosi};
        if (strb.captureCmd) addrQ <= {shiftIn[ADDR_W-2:0], mosi};
        if (strb.commitWrite) begin
          wrDataQ <= {shiftIn, mosi};
          wrEnQ   <= !isStatus;
        end
        if (strb.loadRead) shiftOutQ <= rdWord;
        else if (strb.shiftOut) shiftOutQ <= {shiftOutQ[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign regAddr   = addrQ;
  assign regWrData = wrDataQ;
  assign regWrEn   = wrEnQ;
  assign misoOut   = shiftOutQ[BYTE_W-1];
  assign misoOe    = !csN && (!odMode || !shiftOutQ[BYTE_W-1]);

  // R9: status addresses never see a write strobe
  p_status_ro_r9: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regAddr >= STATUS_LIMIT));

  // R5: write strobe lasts a single cycle
  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R4: open-drain drive never pushes a one
  p_od_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (odMode && misoOe) |-> !misoOut);

  // R3: deselected output stays off
  p_hiz_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> !misoOe);

  // R11: a new frame starts with a zero on the output
  p_first_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(csN)) |-> !misoOut);

endmodule

// File: rtl/spi_rw_slave.sv
module spi_rw_slave
  import spi_rw_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int ADDR_W     = 5,
  parameter int NUM_STATUS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              odMode,
  output logic              misoOut,
  output logic              misoOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  input  logic [BYTE_W-1:0] regRdData
);

  ctrl_strobe_t strb;
  logic         rxMsb;

  spi_rw_ctrl #(.BYTE_W(BYTE_W)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .sclk  (sclk),
    .rxMsb (rxMsb),
    .strb  (strb)
  );

  spi_rw_datapath #(
    .BYTE_W     (BYTE_W),
    .ADDR_W     (ADDR_W),
    .NUM_STATUS (NUM_STATUS)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .csN       (csN),
    .mosi      (mosi),
    .odMode    (odMode),
    .regRdData (regRdData),
    .rxMsb     (rxMsb),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWrEn   (regWrEn),
    .misoOut   (misoOut),
    .misoOe    (misoOe)
  );

endmodule

// File: tb/tb_spi_rw_slave.sv
module tb_spi_rw_slave;

  logic       clk = 1'b0;
  logic       rstN, csN, sclk, mosi, odMode;
  logic       misoOut, misoOe, regWrEn;
  logic [4:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic       busBit;

  logic [7:0]  fileRegs [32];
  logic [7:0]  modelRegs [32];
  logic [12:0] expWrQ [$];
  logic [7:0]  txQ [$];
  int checkCnt = 0;
  int failCnt  = 0;
  int cycles   = 0;

  always #4 clk = ~clk;

  spi_rw_slave dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .odMode(odMode), .misoOut(misoOut), .misoOe(misoOe),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdData(regRdData)
  );

  assign busBit    = misoOe ? misoOut : 1'b1;  // pull-up when released
  assign regRdData = fileRegs[regAddr];

  always @(posedge clk) if (regWrEn) fileRegs[regAddr] <= regWrData;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] withParity(input logic [4:0] a, input logic [7:0] v);
    if (a < 5'd3) return {^v[6:0], v[6:0]};
    return v;
  endfunction

  // Write strobe monitor: every pulse must match the model (R5, R9)
  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      if (expWrQ.size() == 0) chk(1'b0, "R9 unexpected write", {regAddr, regWrData}, 0);
      else begin
        logic [12:0] e;
        e = expWrQ.pop_front();
        chk(e == {regAddr, regWrData}, "R5 write", {regAddr, regWrData}, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  task automatic spiBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    logic first;
    rx = '0;
    for (int i = 7; i >= 8 - n; i--) begin
      mosi = tx[i];
      repeat (3) @(negedge clk);
      first = busBit;
      rx[i] = first;
      if (odMode) chk(!(misoOe && misoOut), "R4 od drive", misoOe, 0);
      else        chk(misoOe, "R4 push-pull enable", misoOe, 1);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      chk(busBit == first, "R1 stable while high", busBit, first);
      sclk = 1'b0;
      @(negedge clk);
    end
  endtask

  // Runs txQ as one frame, predicting output bytes and writes
  task automatic runFrame(input string name);
    logic [7:0] rx, expNow, expNext;
    logic       wantData;
    logic [4:0] wAddr;
    csN = 1'b0;
    repeat (2) @(negedge clk);
    expNext = 8'h00; wantData = 1'b0; wAddr = '0;
    for (int k = 0; k < txQ.size(); k++) begin
      expNow = expNext;
      expNext = 8'h00;
      if (wantData && wAddr >= 5'd3) begin
        modelRegs[wAddr] = txQ[k];
        expWrQ.push_back({wAddr, txQ[k]});
      end
      spiBits(txQ[k], 8, rx);
      if (k == 0) chk(rx == expNow, {"R11 first byte ", name}, rx, expNow);
      else        chk(rx == expNow, {"R6 R7 R8 read byte ", name}, rx, expNow);
      if (wantData) wantData = 1'b0;
      else if (txQ[k][7]) begin
        wantData = 1'b1; wAddr = txQ[k][4:0];
      end else expNext = withParity(txQ[k][4:0], modelRegs[txQ[k][4:0]]);
    end
    repeat (3) @(negedge clk);
    csN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!misoOe, "R3 released after frame", misoOe, 0);
    txQ.delete();
  endtask

  initial begin
    logic [7:0] junk;
    for (int i = 0; i < 32; i++) begin
      fileRegs[i]  = 8'(i * 29 + 3);
      modelRegs[i] = 8'(i * 29 + 3);
    end
    fileRegs[0] = 8'h80; modelRegs[0] = 8'h80;
    fileRegs[2] = 8'hC0; modelRegs[2] = 8'hC0;
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; mosi = 1'b0; odMode = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!misoOe, "R3 reset enable", misoOe, 0);
    chk(!regWrEn, "R3 reset strobe", regWrEn, 0);

    // R5 plain write, R6 read back
    txQ = '{8'h85, 8'h55};                       runFrame("write5");
    txQ = '{8'h05, 8'h00};                       runFrame("read5");
    // R7 chained reads and a write inside one frame
    txQ = '{8'h05, 8'h0A, 8'h8C, 8'h77, 8'h0C, 8'h00}; runFrame("chain");
    // R8 parity on status words
    txQ = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h00};  runFrame("status");
    // R9 status writes ignored, then read back unchanged
    txQ = '{8'h81, 8'h3C, 8'h82, 8'hFF, 8'h01, 8'h02, 8'h00}; runFrame("status_wr");
    // R2 bits 6..5 of the command do not matter
    txQ = '{8'hE7, 8'h99, 8'h67, 8'h00};         runFrame("cmd_bits");
    txQ = '{8'hB3, 8'h5A, 8'h53, 8'h00};         runFrame("cmd_bits2");

    // R10 write aborted mid data byte
    csN = 1'b0; repeat (2) @(negedge clk);
    spiBits(8'h88, 8, junk);
    chk(junk == 8'h00, "R11 aborted frame first byte", junk, 0);
    spiBits(8'hFF, 5, junk);
    csN = 1'b1; repeat (4) @(negedge clk);
    txQ = '{8'h08, 8'h00};                       runFrame("after_abort");
    // R10 partial command discarded, next frame aligned
    csN = 1'b0; repeat (2) @(negedge clk);
    spiBits(8'hFF, 3, junk);
    csN = 1'b1; repeat (4) @(negedge clk);
    txQ = '{8'h08, 8'h1F, 8'h00};                runFrame("after_partial");

    // R4 open-drain drive
    odMode = 1'b1;
    txQ = '{8'h05, 8'h02, 8'h9E, 8'hA5, 8'h1E, 8'h00}; runFrame("open_drain");
    odMode = 1'b0;

    repeat (10) @(negedge clk);
    chk(expWrQ.size() == 0, "R5 all writes seen", expWrQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule